// File: doc/BRIEF.md
# Hysteresis Edge Thresholder

This block takes a raster-ordered stream of thinned gradient magnitudes and produces a binary edge map. Each magnitude is first sorted into one of three classes: strong, weak or none. The split uses two thresholds that can be changed at run time. Two line buffers hold the class codes of the two previous rows, and together with the current row they form a 3x3 window. The pixel at the centre of that window is then judged. A strong centre is always an edge. A weak centre is an edge only when at least one of its eight surrounding pixels is strong. Anything else is background.

A frame is a gapless burst of `IMG_W*IMG_H` magnitudes. The first magnitude of the burst carries the start-of-frame flag. The block paces itself from that flag and drains the last row without further input. The threshold inputs are read only on the accepted start-of-frame cycle, so one frame is always judged against one threshold pair. Each output pixel is 255 (edge) or 0 (background). It comes with a valid strobe and with first-pixel and last-pixel markers.

Top module: `hyst_edge_top`

## Requirements
- R1: A magnitude strictly greater than the high threshold is class strong (code 2'b10).
- R2: A magnitude equal to the high threshold is weak (code 2'b01) when it is also above the low threshold. A magnitude less than or equal to the low threshold is class none (code 2'b00) and is never an edge.
- R3: A strong pixel always produces 255 at the output.
- R4: A weak pixel produces 255 if any of its eight neighbours is strong, diagonals included, and 0 otherwise. A weak neighbour does not rescue it.
- R5: Neighbour positions that lie outside the image count as class none. This covers a strong pixel at the end of the previous row, the last row of the previous frame, and stale data in the line buffers.
- R6: The thresholds are captured on the cycle that accepts a start of frame, and that cycle already uses the new values. Threshold changes later in the frame have no effect on that frame.
- R7: Each output pixel is exactly 8'd255 or 8'd0. Exactly `IMG_W*IMG_H` valid outputs appear per frame, in raster order. The input pixel driven into cycle n appears at the output IMG_W+4 cycles later.
- R8: `out_sof` is set together with the first valid output of a frame, and `out_eof` together with the last.
- R9: A start-of-frame flag that arrives while the block is still busy with the previous frame is ignored. The block stays busy from acceptance until IMG_W+1 cycles after the last input pixel.
- R10: After reset, `out_valid`, `out_sof`, `out_eof` and `out_pix` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, synchronously released |
| in_valid | input | 1 | Qualifies `in_sof`; held high for the whole frame burst |
| in_sof | input | 1 | Marks the first magnitude of a frame |
| in_mag | input | MAG_W | Gradient magnitude |
| thr_hi | input | MAG_W | High threshold, sampled at accepted start of frame |
| thr_lo | input | MAG_W | Low threshold, sampled at accepted start of frame |
| out_valid | output | 1 | Output pixel valid |
| out_pix | output | 8 | 255 for edge, 0 for background |
| out_sof | output | 1 | First output pixel of a frame |
| out_eof | output | 1 | Last output pixel of a frame |

## Verification
Two functions can fall in the same cycle. Threshold capture happens on the start-of-frame cycle, while that same cycle's magnitude is already being classified. One frame provokes this by presenting new threshold values only on its first pixel and switching them to very different values from the second pixel on. Every pixel of that frame must still match a model that uses only the first-cycle pair. The second overlap is a start-of-frame flag raised while the previous frame is still draining, which coincides with that frame's last outputs. Every output is checked against a cycle-stamped queue, so any stray or shifted pixel shows up as a failure.

// File: rtl/hyst_pkg.sv
package hyst_pkg;

  // Two-bit pixel class carried through the line buffers
  typedef enum logic [1:0] {
    CLS_NONE   = 2'b00,
    CLS_WEAK   = 2'b01,
    CLS_STRONG = 2'b10
  } cls_e;

endpackage

// File: rtl/hyst_classify.sv
module hyst_classify
  import hyst_pkg::*;
#(
  parameter int MAG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [MAG_W-1:0] in_mag,
  input  logic [MAG_W-1:0] thr_hi,
  input  logic [MAG_W-1:0] thr_lo,
  output cls_e             cls_o
);

  logic [MAG_W-1:0] hi_q, lo_q;
  logic [MAG_W-1:0] hi_eff, lo_eff;
  cls_e             cls_d, cls_q;

  // the accepting cycle already uses the fresh pair
  always_comb begin
    hi_eff = accept ? thr_hi : hi_q;
    lo_eff = accept ? thr_lo : lo_q;
    if (in_mag > hi_eff)      cls_d = CLS_STRONG;
    else if (in_mag > lo_eff) cls_d = CLS_WEAK;
    else                      cls_d = CLS_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (accept) begin
      hi_q <= thr_hi;
      lo_q <= thr_lo;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cls_q <= CLS_NONE;
    else        cls_q <= cls_d;
  end

  assign cls_o = cls_q;

endmodule

// File: rtl/hyst_seq.sv
module hyst_seq #(
  parameter int IMG_W = 16,
  parameter int IMG_H = 8,
  localparam int NPIX      = IMG_W * IMG_H,
  localparam int LAST_SLOT = NPIX + IMG_W,
  localparam int FIRST_CTR = IMG_W + 1,
  localparam int SLOT_W    = $clog2(LAST_SLOT + 1),
  localparam int CX_W      = $clog2(IMG_W),
  localparam int CY_W      = $clog2(IMG_H)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sof,
  output logic              accept,
  output logic              run_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              ctr_vld_o,
  output logic [CX_W-1:0]   cx_o,
  output logic [CY_W-1:0]   cy_o
);

  logic              run_d, run_q;
  logic [SLOT_W-1:0] slot_d, slot_q;
  logic              ctr_vld_d, ctr_vld_q;
  logic [CX_W-1:0]   cx_d, cx_q;
  logic [CY_W-1:0]   cy_d, cy_q;

  always_comb begin
    accept = in_valid && in_sof && !run_q;
    run_d  = run_q;
    slot_d = slot_q;
    if (accept) begin
      run_d  = 1'b1;
      slot_d = '0;
    end else if (run_q) begin
      if (slot_q == SLOT_W'(LAST_SLOT)) run_d  = 1'b0;
      else                              slot_d = slot_q + SLOT_W'(1);
    end

    // window centre trails the newest slot by one row plus one pixel
    ctr_vld_d = run_q && (slot_q >= SLOT_W'(FIRST_CTR));
    cx_d      = cx_q;
    cy_d      = cy_q;
    if (run_q && slot_q == SLOT_W'(FIRST_CTR)) begin
      cx_d = '0;
      cy_d = '0;
    end else if (ctr_vld_d) begin
      if (cx_q == CX_W'(IMG_W - 1)) begin
        cx_d = '0;
        cy_d = cy_q + CY_W'(1);
      end else begin
        cx_d = cx_q + CX_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q     <= 1'b0;
      slot_q    <= '0;
      ctr_vld_q <= 1'b0;
      cx_q      <= '0;
      cy_q      <= '0;
    end else begin
      run_q     <= run_d;
      slot_q    <= slot_d;
      ctr_vld_q <= ctr_vld_d;
      cx_q      <= cx_d;
      cy_q      <= cy_d;
    end
  end

  assign run_o     = run_q;
  assign slot_o    = slot_q;
  assign ctr_vld_o = ctr_vld_q;
  assign cx_o      = cx_q;
  assign cy_o      = cy_q;

endmodule

// File: rtl/hyst_linebuf.sv
module hyst_linebuf
  import hyst_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  cls_e din,
  output cls_e dout
);

  cls_e sr_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) sr_q[i] <= CLS_NONE;
    end else if (en) begin
      sr_q[0] <= din;
      for (int i = 1; i < DEPTH; i++) sr_q[i] <= sr_q[i-1];
    end
  end

  assign dout = sr_q[DEPTH-1];

endmodule

// File: rtl/hyst_window.sv
module hyst_window
  import hyst_pkg::*;
#(
  parameter int IMG_W = 16,
  parameter int IMG_H = 8,
  localparam int CX_W = $clog2(IMG_W),
  localparam int CY_W = $clog2(IMG_H)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            shift_en,
  input  cls_e            row_src [3],
  input  logic            ctr_vld,
  input  logic [CX_W-1:0] cx,
  input  logic [CY_W-1:0] cy,
  output logic            out_valid,
  output logic [7:0]      out_pix,
  output logic            out_sof,
  output logic            out_eof
);

  // win_q[r][c]: r=0 row below centre, r=2 row above; c=2 rightmost
  cls_e       win_q [3][3];
  logic [2:0] row_ok, col_ok;
  logic       any_strong, keep;
  logic       vld_d, sof_d, eof_d;
  logic [7:0] pix_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < 3; r++)
        for (int c = 0; c < 3; c++) win_q[r][c] <= CLS_NONE;
    end else if (shift_en) begin
      for (int r = 0; r < 3; r++) begin
        win_q[r][0] <= win_q[r][1];
        win_q[r][1] <= win_q[r][2];
        win_q[r][2] <= row_src[r];
      end
    end
  end

  always_comb begin
    row_ok[0] = (cy != CY_W'(IMG_H - 1));
    row_ok[1] = 1'b1;
    row_ok[2] = (cy != '0);
    col_ok[0] = (cx != '0);
    col_ok[1] = 1'b1;
    col_ok[2] = (cx != CX_W'(IMG_W - 1));
    any_strong = 1'b0;
    for (int r = 0; r < 3; r++)
      for (int c = 0; c < 3; c++)
        if (!(r == 1 && c == 1) && row_ok[r] && col_ok[c] &&
            win_q[r][c] == CLS_STRONG)
          any_strong = 1'b1;
    keep  = (win_q[1][1] == CLS_STRONG) ||
            (win_q[1][1] == CLS_WEAK && any_strong);
    vld_d = ctr_vld;
    pix_d = (ctr_vld && keep) ? 8'hFF : 8'h00;
    sof_d = ctr_vld && cx == '0 && cy == '0;
    eof_d = ctr_vld && cx == CX_W'(IMG_W - 1) && cy == CY_W'(IMG_H - 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pix   <= 8'h00;
      out_sof   <= 1'b0;
      out_eof   <= 1'b0;
    end else begin
      out_valid <= vld_d;
      out_pix   <= pix_d;
      out_sof   <= sof_d;
      out_eof   <= eof_d;
    end
  end

endmodule

// File: rtl/hyst_edge_top.sv
module hyst_edge_top
  import hyst_pkg::*;
#(
  parameter int IMG_W = 16,
  parameter int IMG_H = 8,
  parameter int MAG_W = 8,
  localparam int NPIX   = IMG_W * IMG_H,
  localparam int SLOT_W = $clog2(NPIX + IMG_W + 1),
  localparam int CX_W   = $clog2(IMG_W),
  localparam int CY_W   = $clog2(IMG_H),
  localparam int NLINES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic [MAG_W-1:0] in_mag,
  input  logic [MAG_W-1:0] thr_hi,
  input  logic [MAG_W-1:0] thr_lo,
  output logic             out_valid,
  output logic [7:0]       out_pix,
  output logic             out_sof,
  output logic             out_eof
);

  logic              accept;
  logic              run_q;
  logic [SLOT_W-1:0] slot_q;
  logic              ctr_vld;
  logic [CX_W-1:0]   cx;
  logic [CY_W-1:0]   cy;
  cls_e              line_tap [NLINES+1];

  hyst_seq #(.IMG_W(IMG_W), .IMG_H(IMG_H)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_sof   (in_sof),
    .accept   (accept),
    .run_o    (run_q),
    .slot_o   (slot_q),
    .ctr_vld_o(ctr_vld),
    .cx_o     (cx),
    .cy_o     (cy)
  );

  hyst_classify #(.MAG_W(MAG_W)) u_cls (
    .clk    (clk),
    .rst_n  (rst_n),
    .accept (accept),
    .in_mag (in_mag),
    .thr_hi (thr_hi),
    .thr_lo (thr_lo),
    .cls_o  (line_tap[0])
  );

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    hyst_linebuf #(.DEPTH(IMG_W)) u_lb (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (run_q),
      .din  (line_tap[g]),
      .dout (line_tap[g+1])
    );
  end

  hyst_window #(.IMG_W(IMG_W), .IMG_H(IMG_H)) u_win (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (run_q),
    .row_src  (line_tap),
    .ctr_vld  (ctr_vld),
    .cx       (cx),
    .cy       (cy),
    .out_valid(out_valid),
    .out_pix  (out_pix),
    .out_sof  (out_sof),
    .out_eof  (out_eof)
  );

endmodule

// File: rtl/hyst_edge_chk.sv
module hyst_edge_chk #(
  parameter int IMG_W = 16,
  parameter int IMG_H = 8,
  localparam int NPIX   = IMG_W * IMG_H,
  localparam int LAST   = NPIX + IMG_W,
  localparam int SLOT_W = $clog2(LAST + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run_q,
  input logic [SLOT_W-1:0] slot_q,
  input logic              out_valid,
  input logic [7:0]        out_pix,
  input logic              out_sof,
  input logic              out_eof
);

  a_r7_binary_pixel: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_pix == 8'hFF || out_pix == 8'h00));

  a_r8_sof_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (out_sof || out_eof) |-> out_valid);

  a_r8_sof_opens_frame: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> out_sof);

  a_r8_eof_closes_frame: assert property (@(posedge clk) disable iff (!rst_n)
    out_eof |=> !out_valid);

  // R9: while busy the slot counter only advances, whatever in_sof does
  a_r9_busy_advances: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && slot_q != SLOT_W'(LAST)) |=>
      (run_q && slot_q == $past(slot_q) + SLOT_W'(1)));

  a_r10_idle_output_low: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> out_pix == 8'h00);

endmodule

bind hyst_edge_top hyst_edge_chk #(.IMG_W(IMG_W), .IMG_H(IMG_H)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .run_q    (run_q),
  .slot_q   (slot_q),
  .out_valid(out_valid),
  .out_pix  (out_pix),
  .out_sof  (out_sof),
  .out_eof  (out_eof)
);

// File: tb/test_hyst_edge_top.sv
module test_hyst_edge_top;

  localparam int W    = 16;
  localparam int H    = 8;
  localparam int NPIX = W * H;
  localparam int LAT  = W + 4;

  typedef struct {
    logic [7:0] pix;
    logic       sof;
    logic       eof;
    int         cyc;
    string      tag;
  } exp_t;

  logic       clk, rst_n, in_valid, in_sof, out_valid, out_sof, out_eof;
  logic [7:0] in_mag, thr_hi, thr_lo, out_pix;

  exp_t exp_q[$];
  int   img [NPIX];
  int   n_run, n_fail, cyc;
  bit   done;

  hyst_edge_top #(.IMG_W(W), .IMG_H(H), .MAG_W(8)) i_hyst_edge_top (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_mag(in_mag), .thr_hi(thr_hi), .thr_lo(thr_lo),
    .out_valid(out_valid), .out_pix(out_pix), .out_sof(out_sof), .out_eof(out_eof)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R9", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(cyc == e.cyc, "R7", cyc, e.cyc);
        check(out_pix == e.pix, e.tag, out_pix, e.pix);
        check({out_sof, out_eof} == {e.sof, e.eof}, "R8", {out_sof, out_eof}, {e.sof, e.eof});
      end
    end
  end

  function automatic int cls_of(input int m, input int hi, input int lo);
    if (m > hi) return 2;
    if (m > lo) return 1;
    return 0;
  endfunction

  task automatic send_frame(input int hi, input int lo, input bit mid_change);
    int   cl [NPIX];
    exp_t e;
    for (int i = 0; i < NPIX; i++) cl[i] = cls_of(img[i], hi, lo);
    for (int p = 0; p < NPIX; p++) begin
      int  x = p % W;
      int  y = p / W;
      bit  near = 1'b0;
      bit  kept;
      for (int dy = -1; dy <= 1; dy++)
        for (int dx = -1; dx <= 1; dx++)
          if ((dx != 0 || dy != 0) && x + dx >= 0 && x + dx < W &&
              y + dy >= 0 && y + dy < H && cl[(y + dy) * W + x + dx] == 2)
            near = 1'b1;
      kept = (cl[p] == 2) || (cl[p] == 1 && near);
      @(negedge clk);
      in_valid = 1'b1;
      in_sof   = (p == 0);
      in_mag   = 8'(img[p]);
      if (p == 0 || !mid_change) begin
        thr_hi = 8'(hi);
        thr_lo = 8'(lo);
      end else begin
        thr_hi = 8'd20;
        thr_lo = 8'd10;
      end
      e.pix = kept ? 8'hFF : 8'h00;
      e.sof = (p == 0);
      e.eof = (p == NPIX - 1);
      e.cyc = cyc + LAT;
      if (mid_change)                      e.tag = "R6";
      else if (cl[p] == 2)                 e.tag = "R3";
      else if (cl[p] == 1 && !kept && (x == 0 || x == W - 1 || y == 0 || y == H - 1))
                                           e.tag = "R5";
      else if (cl[p] == 1)                 e.tag = "R4";
      else if (img[p] > 0)                 e.tag = "R2";
      else                                 e.tag = "R1";
      exp_q.push_back(e);
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_sof   = 1'b0;
    in_mag   = 8'd0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R7: watchdog expired, actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    cyc = 0; n_run = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; in_valid = 1'b0; in_sof = 1'b0; in_mag = '0;
    thr_hi = '0; thr_lo = '0;
    repeat (3) @(negedge clk);
    check(!out_valid && !out_sof && !out_eof, "R10", {out_valid, out_sof, out_eof}, 0);
    check(out_pix == 8'h00, "R10", out_pix, 0);
    rst_n = 1'b1;
    idle(4);
    check(!out_valid, "R10", out_valid, 0);

    // frame 1: directed classes, diagonals, row wrap
    for (int i = 0; i < NPIX; i++) img[i] = 0;
    img[1*W + 2]     = 101;  // just above hi: strong (R1)
    img[1*W + 5]     = 100;  // equal to hi, isolated weak -> 0 (R2)
    img[3*W + 4]     = 200;  // strong
    img[4*W + 5]     = 51;   // diagonal weak -> kept (R4)
    img[4*W + 3]     = 50;   // equal to lo -> none (R2)
    img[3*W + 6]     = 60;   // weak two away -> dropped (R4)
    img[5*W + W - 1] = 255;  // strong at row end
    img[6*W + 0]     = 90;   // weak at next row start -> dropped (R5)
    img[6*W + W - 1] = 90;   // weak below strong -> kept
    img[(H-1)*W + 8] = 220;  // strong on bottom row
    send_frame(100, 50, 1'b0);

    // R9: start flag during drain is ignored
    idle(2);
    in_valid = 1'b1; in_sof = 1'b1; in_mag = 8'd250;
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_mag = 8'd0;
    idle(W + 10);
    check(exp_q.size() == 0, "R9", exp_q.size(), 0);

    // frame 2: top row weak below previous frame's strong (R5), thresholds change mid-frame (R6)
    for (int i = 0; i < NPIX; i++) img[i] = 0;
    img[0*W + 8] = 70;
    img[3*W + 3] = 70;
    img[5*W + 9] = 101;
    img[5*W + 10] = 80;
    send_frame(100, 50, 1'b1);
    idle(W + 8);

    // frame 3: random content with thresholds changing mid-frame
    for (int i = 0; i < NPIX; i++) img[i] = $urandom_range(0, 255);
    send_frame(170, 80, 1'b1);
    idle(W + 8);

    // frame 4: random content, sparse strong, many weak
    for (int i = 0; i < NPIX; i++) img[i] = $urandom_range(0, 200);
    send_frame(190, 40, 1'b0);
    idle(W + 8);

    // frame 5: low above high, anything over hi is strong
    for (int i = 0; i < NPIX; i++) img[i] = $urandom_range(0, 80);
    send_frame(40, 200, 1'b0);
    idle(W + 8);

    check(exp_q.size() == 0, "R7", exp_q.size(), 0);
    done = 1'b1;
    finish_run();
  end

endmodule